// File: doc/BRIEF.md
# Video Field Start and Parity Detector

This block sits behind a video input port and turns raw horizontal and vertical sync inputs, plus an optional field-indicator pin, into clean timing events for the capture logic. Each raw input is first synchronised to the block clock. HSYNC and VSYNC are then mapped to active-high form under programmable polarity. The start of every field is found on a selectable edge of VSYNC.

At each field start the block decides whether the new field is odd or even. It can read this from the field-indicator pin. It can also derive it from line timing: a counter measures how far into the current line the VSYNC edge arrived. An edge close to the HSYNC leading edge counts as "with HSYNC", and anything later counts as mid-line. The block produces a one-cycle field-start strobe, a matching vertical-counter reset, a held parity flag and a sticky error. The error records a field start that arrived while the downstream stage still reported the previous field as busy.

All configuration arrives as static level inputs driven by a register block.

Top module: `vsync_field_id`

## Requirements
- R1: Each raw input passes through a two-flop synchroniser. `hsync_out` and `vsync_out` are the active-high normalised syncs, where a polarity input of 1 means the raw sync is active high and 0 means it is active low. A raw level change shows on these outputs after exactly three rising clock edges.
- R2: With `cfg_start_on_trail` = 0, a field starts on the change of `vsync_out` from 0 to 1. With `cfg_start_on_trail` = 1, it starts on the change from 1 to 0. The opposite VSYNC edge produces no field start.
- R3: `field_start` and `vcnt_rst` are both high for exactly one cycle. That cycle comes three rising edges after the raw VSYNC change that starts the field.
- R4: With `cfg_parity_from_pin` = 1, `field_odd` is set to 1 when the synchronised `fld_raw` level equals `cfg_fld_odd_high` at the field start, and to 0 otherwise. The value of `cfg_odd_on_midline` has no effect in this mode.
- R5: With `cfg_parity_from_pin` = 0, the field edge is "with HSYNC" if it arrives at most `cfg_near_win` clock cycles after the raw HSYNC leading edge, counting the same cycle as 0. Otherwise it is mid-line. `field_odd` becomes 1 for "with HSYNC" when `cfg_odd_on_midline` = 0, and 1 for mid-line when `cfg_odd_on_midline` = 1.
- R6: If no HSYNC leading edge has been seen since reset, a field edge in line-timing mode is treated as mid-line.
- R7: `field_odd` changes only in the cycle in which `field_start` is high, and holds its value until the next field start.
- R8: `frame_err` is set when `busy_in` is high in the cycle that precedes `field_start`. It stays set until `err_clear` is high for a cycle, and then reads 0 after the next rising edge. If a set and a clear coincide, the set wins.
- R9: While `rst_n` is low, all outputs are 0. Input levels that are already present when reset is released produce no field start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_raw | input | 1 | Raw horizontal sync |
| vsync_raw | input | 1 | Raw vertical sync |
| fld_raw | input | 1 | Raw field-indicator pin |
| cfg_hs_act_high | input | 1 | 1: HSYNC active high, 0: active low |
| cfg_vs_act_high | input | 1 | 1: VSYNC active high, 0: active low |
| cfg_fld_odd_high | input | 1 | Field-pin level that marks an odd field |
| cfg_parity_from_pin | input | 1 | 1: parity from field pin, 0: from line timing |
| cfg_start_on_trail | input | 1 | 1: field starts on VSYNC trailing edge, 0: on leading edge |
| cfg_odd_on_midline | input | 1 | Line-timing mode: 0 odd when with HSYNC, 1 odd when mid-line |
| cfg_near_win | input | HCNT_W | Window in cycles for "with HSYNC" |
| busy_in | input | 1 | Downstream still working on the previous field |
| err_clear | input | 1 | Clears the error flag |
| hsync_out | output | 1 | Normalised active-high HSYNC |
| vsync_out | output | 1 | Normalised active-high VSYNC |
| field_start | output | 1 | One-cycle field-start strobe |
| field_odd | output | 1 | Parity of the current field, 1 = odd |
| vcnt_rst | output | 1 | One-cycle vertical-counter reset |
| frame_err | output | 1 | Sticky late-field error |

## Verification
Every result is due a fixed number of edges after its stimulus. The normalised syncs, the strobe, the counter reset and the new parity all appear after the third rising edge that follows a raw change, because of two synchroniser flops and one output register. The error flag appears on that same edge, and it drops one edge after a clear. The bench drives inputs on falling edges and counts falling edges from the raw change, then samples on the falling edge just before and just after the edge at which each result is due. The gap between the HSYNC and VSYNC changes is set in whole cycles, so that the boundary of the "with HSYNC" window can be hit exactly.

// File: rtl/vfid_pkg.sv
package vfid_pkg;

  // positions of the raw inputs inside the synchroniser bus
  localparam int IN_HS       = 0;
  localparam int IN_VS       = 1;
  localparam int IN_FI       = 2;
  localparam int NUM_SYNC_IN = 3;

  typedef enum logic {
    SRC_LINE_TIMING = 1'b0,
    SRC_PIN         = 1'b1
  } par_src_e;

  typedef enum logic {
    START_LEAD  = 1'b0,
    START_TRAIL = 1'b1
  } start_edge_e;

endpackage

// File: rtl/vfid_sync_chain.sv
module vfid_sync_chain #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/vfid_edge_detect.sv
module vfid_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_sync,
  input  logic act_high,
  input  logic arm,
  input  logic sel_trail,
  output logic level_norm,
  output logic edge_hit
);

  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;

  // normalise: output is 1 while the sync is active
  assign level_norm = act_high ? level_sync : ~level_sync;

  assign prev_d = level_norm;
  assign rise   = level_norm & ~prev_q;
  assign fall   = ~level_norm & prev_q;

  always_comb begin
    if (!arm) begin
      edge_hit = 1'b0;
    end else if (sel_trail) begin
      edge_hit = fall;
    end else begin
      edge_hit = rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/vfid_line_pos.sv
module vfid_line_pos #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] pos
);

  localparam logic [W-1:0] POS_MAX = '1;

  logic [W-1:0] pos_q;
  logic [W-1:0] pos_d;
  logic         pos_en;

  // saturate so that a long line (or no line yet) never looks near HSYNC
  assign pos_en = restart | (pos_q != POS_MAX);

  always_comb begin
    if (restart) begin
      pos_d = '0;
    end else begin
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= POS_MAX;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/vfid_field_track.sv
module vfid_field_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic odd_in,
  input  logic busy_in,
  input  logic err_clear,
  output logic field_start,
  output logic field_odd,
  output logic vcnt_rst,
  output logic frame_err
);

  logic start_q, start_d;
  logic vrst_q, vrst_d;
  logic odd_q, odd_d;
  logic err_q, err_d;
  logic err_set;

  assign err_set = start_evt & busy_in;

  always_comb begin
    start_d = start_evt;
    vrst_d  = start_evt;
    odd_d   = start_evt ? odd_in : odd_q;
    if (err_set) begin
      err_d = 1'b1;
    end else if (err_clear) begin
      err_d = 1'b0;
    end else begin
      err_d = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      vrst_q  <= 1'b0;
      odd_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      vrst_q  <= vrst_d;
      odd_q   <= odd_d;
      err_q   <= err_d;
    end
  end

  assign field_start = start_q;
  assign vcnt_rst    = vrst_q;
  assign field_odd   = odd_q;
  assign frame_err   = err_q;

endmodule

// File: rtl/vsync_field_id.sv
module vsync_field_id
  import vfid_pkg::*;
#(
  parameter int HCNT_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_raw,
  input  logic              vsync_raw,
  input  logic              fld_raw,
  input  logic              cfg_hs_act_high,
  input  logic              cfg_vs_act_high,
  input  logic              cfg_fld_odd_high,
  input  logic              cfg_parity_from_pin,
  input  logic              cfg_start_on_trail,
  input  logic              cfg_odd_on_midline,
  input  logic [HCNT_W-1:0] cfg_near_win,
  input  logic              busy_in,
  input  logic              err_clear,
  output logic              hsync_out,
  output logic              vsync_out,
  output logic              field_start,
  output logic              field_odd,
  output logic              vcnt_rst,
  output logic              frame_err
);

  localparam int SETTLE_W = SYNC_STAGES + 1;

  logic [NUM_SYNC_IN-1:0] raw_bus;
  logic [NUM_SYNC_IN-1:0] sync_bus;
  logic [SETTLE_W-1:0]    settle_q;
  logic [SETTLE_W-1:0]    settle_d;
  logic                   arm;
  logic                   hs_lvl, vs_lvl;
  logic                   hs_lead, vs_field_edge;
  logic [HCNT_W-1:0]      line_pos;
  logic                   near_hsync;
  logic                   odd_next;
  par_src_e               par_src;
  start_edge_e            start_edge;
  logic                   hs_out_q, hs_out_d;
  logic                   vs_out_q, vs_out_d;

  assign raw_bus[IN_HS] = hsync_raw;
  assign raw_bus[IN_VS] = vsync_raw;
  assign raw_bus[IN_FI] = fld_raw;

  vfid_sync_chain #(
    .WIDTH (NUM_SYNC_IN),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_bus),
    .dout (sync_bus)
  );

  // edges stay masked until the synchroniser and edge history hold real data
  assign settle_d = {settle_q[SETTLE_W-2:0], 1'b1};
  assign arm      = settle_q[SETTLE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else begin
      settle_q <= settle_d;
    end
  end

  assign start_edge = start_edge_e'(cfg_start_on_trail);
  assign par_src    = par_src_e'(cfg_parity_from_pin);

  vfid_edge_detect u_hs_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_sync(sync_bus[IN_HS]),
    .act_high  (cfg_hs_act_high),
    .arm       (arm),
    .sel_trail (1'b0),
    .level_norm(hs_lvl),
    .edge_hit  (hs_lead)
  );

  vfid_edge_detect u_vs_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_sync(sync_bus[IN_VS]),
    .act_high  (cfg_vs_act_high),
    .arm       (arm),
    .sel_trail (start_edge == START_TRAIL),
    .level_norm(vs_lvl),
    .edge_hit  (vs_field_edge)
  );

  vfid_line_pos #(
    .W(HCNT_W)
  ) u_line_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(hs_lead),
    .pos    (line_pos)
  );

  // same-cycle HSYNC edge counts as distance 0
  assign near_hsync = hs_lead | (line_pos < cfg_near_win);

  always_comb begin
    if (par_src == SRC_PIN) begin
      odd_next = (sync_bus[IN_FI] == cfg_fld_odd_high);
    end else begin
      odd_next = near_hsync ^ cfg_odd_on_midline;
    end
  end

  vfid_field_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (vs_field_edge),
    .odd_in     (odd_next),
    .busy_in    (busy_in),
    .err_clear  (err_clear),
    .field_start(field_start),
    .field_odd  (field_odd),
    .vcnt_rst   (vcnt_rst),
    .frame_err  (frame_err)
  );

  assign hs_out_d = hs_lvl;
  assign vs_out_d = vs_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_out_q <= 1'b0;
      vs_out_q <= 1'b0;
    end else begin
      hs_out_q <= hs_out_d;
      vs_out_q <= vs_out_d;
    end
  end

  assign hsync_out = hs_out_q;
  assign vsync_out = vs_out_q;

endmodule

// File: rtl/vfid_checker.sv
module vfid_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_start_on_trail,
  input logic err_clear,
  input logic vsync_out,
  input logic field_start,
  input logic field_odd,
  input logic frame_err
);

  // R3: strobe lasts a single cycle
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !field_start);

  // R2: a start coincides with a change of the normalised VSYNC
  assert_start_on_vs_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> (vsync_out != $past(vsync_out)));

  // R2: the direction of that change follows the edge selection
  assert_start_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |-> (vsync_out == !$past(cfg_start_on_trail)));

  // R7: parity moves only together with a start
  assert_odd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |-> $stable(field_odd));

  // R8: error rises only with a field start
  assert_err_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> field_start);

  // R8: error stays set without a clear
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clear) |=> frame_err);

endmodule

bind vsync_field_id vfid_checker i_vfid_checker (
  .clk               (clk),
  .rst_n             (rst_n),
  .cfg_start_on_trail(cfg_start_on_trail),
  .err_clear         (err_clear),
  .vsync_out         (vsync_out),
  .field_start       (field_start),
  .field_odd         (field_odd),
  .frame_err         (frame_err)
);

// File: tb/test_vsync_field_id.sv
`timescale 1ns/1ps
module test_vsync_field_id;

  localparam int HW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic hs_raw, vs_raw, fi_raw;
  logic c_hspol, c_vspol, c_fipol, c_pin, c_trail, c_mid;
  logic [HW-1:0] c_win;
  logic busy, clr;
  logic hs_out, vs_out, fs, odd, vrst, err;

  always #2.5 clk = ~clk;

  vsync_field_id #(.HCNT_W(HW), .SYNC_STAGES(2)) i_vsync_field_id (
    .clk(clk), .rst_n(rst_n),
    .hsync_raw(hs_raw), .vsync_raw(vs_raw), .fld_raw(fi_raw),
    .cfg_hs_act_high(c_hspol), .cfg_vs_act_high(c_vspol),
    .cfg_fld_odd_high(c_fipol), .cfg_parity_from_pin(c_pin),
    .cfg_start_on_trail(c_trail), .cfg_odd_on_midline(c_mid),
    .cfg_near_win(c_win), .busy_in(busy), .err_clear(clr),
    .hsync_out(hs_out), .vsync_out(vs_out), .field_start(fs),
    .field_odd(odd), .vcnt_rst(vrst), .frame_err(err)
  );

  typedef struct packed {
    logic       pin;
    logic       trail;
    logic       mid;
    logic       fipol;
    logic       hspol;
    logic       vspol;
    logic       fi;
    logic [7:0] d;
    logic       exp_odd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3,  1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4,  1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd10, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1,  1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9,  1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd5,  1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd5,  1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5,  1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd5,  1'b0}
  };

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;

  always @(negedge clk) if (fs === 1'b1) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_cfg(input logic pin, input logic trail, input logic mid,
                         input logic fipol, input logic hspol, input logic vspol);
    c_pin = pin; c_trail = trail; c_mid = mid;
    c_fipol = fipol; c_hspol = hspol; c_vspol = vspol;
    hs_raw = ~hspol; vs_raw = ~vspol;
  endtask

  task automatic run_vec(input vec_t v);
    int p0;
    string rq;
    rq = v.pin ? "R4 pin parity" : "R5 timing parity";
    set_cfg(v.pin, v.trail, v.mid, v.fipol, v.hspol, v.vspol);
    fi_raw = v.fi;
    busy = 1'b0; clr = 1'b0;
    apply_reset();
    if (v.trail) begin
      vs_raw = v.vspol;
      repeat (6) @(negedge clk);
    end
    p0 = pulses;
    for (int k = 0; k <= int'(v.d) + 12; k++) begin
      if (k == 3) chk("R1 hsync_out active", hs_out, 1);
      if (k == 5) chk("R1 hsync_out idle", hs_out, 0);
      if (k == int'(v.d) + 2) chk("R3 no start before third edge", fs, 0);
      if (k == int'(v.d) + 3) begin
        chk("R3 field_start", fs, 1);
        chk("R3 vcnt_rst", vrst, 1);
        chk(rq, odd, v.exp_odd);
        chk("R1 vsync_out level", vs_out, v.trail ? 0 : 1);
      end
      if (k == int'(v.d) + 4) chk("R3 single cycle", fs, 0);
      hs_raw = (k < 2) ? v.hspol : ~v.hspol;
      if (k == int'(v.d)) vs_raw = v.trail ? ~v.vspol : v.vspol;
      @(negedge clk);
    end
    // R7: disturb the parity sources without a field edge
    fi_raw = ~v.fi;
    hs_raw = v.hspol;
    repeat (2) @(negedge clk);
    hs_raw = ~v.hspol;
    repeat (6) @(negedge clk);
    chk("R7 parity held", odd, v.exp_odd);
    chk("R2 R9 exactly one start", pulses - p0, 1);
  endtask

  initial begin
    c_win = HW'(3);
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    fi_raw = 1'b0; busy = 1'b0; clr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs during reset
    chk("R9 reset field_start", fs, 0);
    chk("R9 reset field_odd", odd, 0);
    chk("R9 reset frame_err", err, 0);
    chk("R9 reset vcnt_rst", vrst, 0);
    chk("R9 reset hsync_out", hs_out, 0);
    chk("R9 reset vsync_out", vs_out, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R6: no HSYNC since reset -> mid-line, odd when mid-line selected
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    apply_reset();
    vs_raw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 start without hsync", fs, 1);
    chk("R6 mid-line parity", odd, 1);

    // R8: error set by busy at field start, sticky, cleared
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    apply_reset();
    busy = 1'b1;
    vs_raw = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 no error before start", err, 0);
    @(negedge clk);
    chk("R8 error set", err, 1);
    busy = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 error sticky", err, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R8 error cleared", err, 0);
    vs_raw = 1'b0;
    repeat (4) @(negedge clk);
    vs_raw = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 no error when idle", err, 0);
    // set and clear together: set wins
    vs_raw = 1'b0;
    repeat (4) @(negedge clk);
    busy = 1'b1;
    vs_raw = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    busy = 1'b0;
    chk("R8 set beats clear", err, 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule